// File: doc/BRIEF.md
# Absolute to physical address mapper

This block turns an absolute address into a physical address for accesses made while virtual translation is switched off. A 64-bit absolute address comes in together with two mode flags. One flag selects a wide absolute mode. The other marks a legacy 32-bit architecture. One clock later the block returns a physical address of configurable width, together with a permission vector. With translation off, that vector always grants read, write and execute.

In wide mode the low physical-width bits of the address pass straight through. In narrow mode only the low 32 bits count. When the legacy flag is clear, the top byte of those 32 bits picks one of three spaces, and each space fills the bits above bit 31 in its own way. Memory space fills them with zeros. The I/O space fills them with ones, which is a sign extension. In the firmware space every bit is zero except the top four, which are forced to one. When the legacy flag is set, narrow mode always fills with zeros. The output is registered, in the FPGA style of the surrounding code base, so the latency is one cycle.

Top module: `abs_phys_mapper`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `phys_addr` = 0 and `perm_rwx` = 0.
- R2: The outputs change one clock edge after the inputs. Back-to-back inputs produce back-to-back results with no gap, and bits 31:0 of `phys_addr` always equal bits 31:0 of the address sampled at the previous edge.
- R3: With `wide_mode` = 1, `phys_addr` equals bits PHYS_W-1:0 of `abs_addr`.
- R4: With `wide_mode` = 0 and `legacy_arch` = 0, an address whose bits 31:28 are not 4'hF is in memory space, and bits PHYS_W-1:32 of `phys_addr` are all zero.
- R5: With `wide_mode` = 0 and `legacy_arch` = 0, an address whose bits 31:28 are 4'hF and whose bits 27:24 are not zero is in I/O space, and bits PHYS_W-1:32 are all one.
- R6: With `wide_mode` = 0 and `legacy_arch` = 0, an address whose bits 31:24 are 8'hF0 is in firmware space. Bits PHYS_W-1:PHYS_W-4 are one and bits PHYS_W-5:32 are zero.
- R7: With `wide_mode` = 0 and `legacy_arch` = 1, there is no space decode. Bits PHYS_W-1:32 are zero for every address, including those with a top byte of 8'hF0 or 8'hF1.
- R8: After the first edge with `rst` low, `perm_rwx` is 3'b111, where bit 2 is read, bit 1 is write and bit 0 is execute.
- R9: In narrow mode, bits 63:32 of `abs_addr` have no effect on `phys_addr`.
- R10: When `wide_mode` = 1, the `legacy_arch` flag has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| abs_addr | input | 64 | Absolute address |
| wide_mode | input | 1 | 1 selects wide absolute mode |
| legacy_arch | input | 1 | 1 selects legacy 32-bit narrow behaviour |
| phys_addr | output | PHYS_W | Physical address, registered |
| perm_rwx | output | 3 | Granted permissions {read, write, execute}, registered |

## Verification
An error in the space decoder shows up in the very next output word. A firmware address, for example, would come out with the wrong fill above bit 31. That is why the bench walks each space up to its boundary top byte (8'hEF, 8'hF0, 8'hF1, 8'hFF). A stale or skipped output register shows up as a result that lags or lingers by one cycle, so back-to-back inputs are checked on every cycle. A permission or reset register stuck at the wrong value is visible at the first sample after reset.

// File: rtl/apm_pkg.sv
package apm_pkg;
  localparam int ABS_W  = 64;
  localparam int LOW_W  = 32;
  localparam int PERM_W = 3;

  typedef enum logic [1:0] {
    SPACE_MEM = 2'd0,
    SPACE_IO  = 2'd1,
    SPACE_FW  = 2'd2
  } space_e;

  localparam logic [PERM_W-1:0] PERM_ALL = 3'b111;
endpackage

// File: rtl/apm_space_decode.sv
module apm_space_decode
  import apm_pkg::*;
(
  input  logic [7:0] top_byte,
  output space_e     space
);
  logic hi_nib_f;
  logic lo_nib_zero;

  always_comb begin
    hi_nib_f    = (top_byte[7:4] == 4'hF);
    lo_nib_zero = (top_byte[3:0] == 4'h0);
    if (!hi_nib_f)        space = SPACE_MEM;
    else if (!lo_nib_zero) space = SPACE_IO;
    else                  space = SPACE_FW;
  end

  // R5
  io_needs_f_chk: assert final ((space != SPACE_IO) || (top_byte[7:4] == 4'hF));
endmodule

// File: rtl/apm_extend.sv
module apm_extend
  import apm_pkg::*;
#(
  parameter int PHYS_W = 40
)(
  input  logic [ABS_W-1:0]  abs_addr,
  input  logic              wide_mode,
  input  logic              legacy_arch,
  input  space_e            space,
  output logic [PHYS_W-1:0] phys_next
);
  localparam int FW_LO = PHYS_W - 4;

  assign phys_next[LOW_W-1:0] = abs_addr[LOW_W-1:0];

  for (genvar j = LOW_W; j < PHYS_W; j++) begin : g_upper
    if (j >= FW_LO) begin : g_fw_bit
      always_comb begin
        if (wide_mode)        phys_next[j] = abs_addr[j];
        else if (legacy_arch) phys_next[j] = 1'b0;
        else                  phys_next[j] = (space == SPACE_IO) || (space == SPACE_FW);
      end
    end else begin : g_plain_bit
      always_comb begin
        if (wide_mode)        phys_next[j] = abs_addr[j];
        else if (legacy_arch) phys_next[j] = 1'b0;
        else                  phys_next[j] = (space == SPACE_IO);
      end
    end
  end
endmodule

// File: rtl/abs_phys_mapper.sv
module abs_phys_mapper
  import apm_pkg::*;
#(
  parameter int PHYS_W = 40
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [63:0]       abs_addr,
  input  logic              wide_mode,
  input  logic              legacy_arch,
  output logic [PHYS_W-1:0] phys_addr,
  output logic [2:0]        perm_rwx
);
  localparam int UP_W = PHYS_W - LOW_W;
  localparam int FW_LO = PHYS_W - 4;

  space_e             space;
  logic [PHYS_W-1:0]  phys_next;

  apm_space_decode u_dec (
    .top_byte (abs_addr[31:24]),
    .space    (space)
  );

  apm_extend #(.PHYS_W(PHYS_W)) u_ext (
    .abs_addr    (abs_addr),
    .wide_mode   (wide_mode),
    .legacy_arch (legacy_arch),
    .space       (space),
    .phys_next   (phys_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_addr <= '0;
      perm_rwx  <= '0;
    end else begin
      phys_addr <= phys_next;
      perm_rwx  <= PERM_ALL;
    end
  end

  // R2
  low_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> phys_addr[31:0] == $past(abs_addr[31:0]));

  // R8
  perm_all_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> perm_rwx == 3'b111);

  // R3
  wide_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wide_mode)) |-> phys_addr == $past(abs_addr[PHYS_W-1:0]));

  // R4
  mem_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wide_mode) && !$past(legacy_arch) && $past(abs_addr[31:28]) != 4'hF)
    |-> phys_addr[PHYS_W-1:LOW_W] == '0);

  // R6
  fw_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wide_mode) && !$past(legacy_arch) && $past(abs_addr[31:24]) == 8'hF0)
    |-> phys_addr[PHYS_W-1:FW_LO] == 4'hF);

  // R7
  legacy_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wide_mode) && $past(legacy_arch))
    |-> phys_addr[PHYS_W-1:LOW_W] == {UP_W{1'b0}});
endmodule

// File: tb/tb_abs_phys_mapper.sv
module tb_abs_phys_mapper;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [63:0]   abs_addr = '0;
  logic          wide_mode = 1'b0;
  logic          legacy_arch = 1'b0;
  logic [PW-1:0] phys_addr;
  logic [2:0]    perm_rwx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  abs_phys_mapper #(.PHYS_W(PW)) dut (
    .clk(clk), .rst(rst), .abs_addr(abs_addr), .wide_mode(wide_mode),
    .legacy_arch(legacy_arch), .phys_addr(phys_addr), .perm_rwx(perm_rwx)
  );

  task automatic check_val(string req, logic [PW-1:0] exp_p, logic [2:0] exp_r);
    checks++;
    if (phys_addr !== exp_p || perm_rwx !== exp_r) begin
      errors++;
      $display("FAIL %s: phys=%h perm=%b expected phys=%h perm=%b",
               req, phys_addr, perm_rwx, exp_p, exp_r);
    end
  endtask

  task automatic one(string req, logic [63:0] a, logic w, logic l, logic [PW-1:0] exp_p);
    @(negedge clk);
    abs_addr = a; wide_mode = w; legacy_arch = l;
    @(negedge clk);
    check_val(req, exp_p, 3'b111);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    abs_addr = 64'hFFFF_FFFF_F000_0000;
    @(negedge clk); @(negedge clk);
    check_val("R1", '0, 3'b000);
    rst = 1'b0;
    @(negedge clk);
    check_val("R8", 40'hF0_F000_0000, 3'b111);
  endtask

  task automatic t_wide();
    one("R3", 64'h1234_5678_9ABC_DEF0, 1'b1, 1'b0, 40'h78_9ABC_DEF0);
    one("R10", 64'h1234_5678_9ABC_DEF0, 1'b1, 1'b1, 40'h78_9ABC_DEF0);
    one("R3", 64'h0000_00FF_F000_0000, 1'b1, 1'b0, 40'hFF_F000_0000);
  endtask

  task automatic t_mem();
    one("R4", 64'hFFFF_FFFF_7000_0004, 1'b0, 1'b0, 40'h00_7000_0004);
    one("R4", 64'h0000_0000_EFFF_FFFF, 1'b0, 1'b0, 40'h00_EFFF_FFFF);
  endtask

  task automatic t_io();
    one("R5", 64'h0000_0000_F100_0000, 1'b0, 1'b0, 40'hFF_F100_0000);
    one("R5", 64'h0000_0000_FFFF_FFFC, 1'b0, 1'b0, 40'hFF_FFFF_FFFC);
  endtask

  task automatic t_fw();
    one("R6", 64'h0000_0000_F000_0000, 1'b0, 1'b0, 40'hF0_F000_0000);
    one("R6", 64'h0000_0000_F0FF_FFFF, 1'b0, 1'b0, 40'hF0_F0FF_FFFF);
    one("R9", 64'hABCD_00FF_F012_3456, 1'b0, 1'b0, 40'hF0_F012_3456);
  endtask

  task automatic t_legacy();
    one("R7", 64'h0000_0000_F000_1234, 1'b0, 1'b1, 40'h00_F000_1234);
    one("R7", 64'hFFFF_FFFF_F100_0000, 1'b0, 1'b1, 40'h00_F100_0000);
  endtask

  task automatic t_stream();
    @(negedge clk);
    abs_addr = 64'h0000_0000_1111_1111; wide_mode = 1'b0; legacy_arch = 1'b0;
    @(negedge clk);
    check_val("R2", 40'h00_1111_1111, 3'b111);
    abs_addr = 64'h0000_0000_F200_0000;
    @(negedge clk);
    check_val("R2", 40'hFF_F200_0000, 3'b111);
    abs_addr = 64'h0000_0000_F000_0001;
    @(negedge clk);
    check_val("R2", 40'hF0_F000_0001, 3'b111);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_val("R1", '0, 3'b000);
    rst = 1'b0;
  endtask

  initial begin
    t_reset();
    t_wide();
    t_mem();
    t_io();
    t_fw();
    t_legacy();
    t_stream();
    t_reset_mid();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule